// File: doc/BRIEF.md
# Message Interrupt Write Termination Bank

This block sinks message-signalled interrupt writes and records each one as a pending bit. A write carries its target in its address and its vector in its data. Bits [22:16] of the write address select one of 128 index registers of 32 bits, numbered 8 × group + index. The low five bits of the data select the bit to set. The 128 registers form 16 groups of 8, which gives 256 vectors per group and 4096 vectors in all.

Each group drives its own level-high interrupt line. The line stays high while any bit in that group is pending. Service software first reads a group's summary register to find which index registers hold pending bits. It then reads those index registers. A read of an index register returns the pending bits and clears them in the same step, so no separate acknowledge write exists. The read port has a latency of one cycle.

Top module: `msi_term_bank`

## Requirements
- R1: After reset every index register is zero, `irq_o` is all zero and `rd_valid_o` is low.
- R2: A write with address bit 23 = 0 and data below 32 sets bit `data[4:0]` of index register `addr[22:16]`, where the register number is 8 × group + index. Address bits [15:0] are ignored.
- R3: A write whose data is 32 or greater changes no register and no interrupt line.
- R4: A write with address bit 23 = 1 changes no register and no interrupt line.
- R5: A read at address group × 0x80000 + index × 0x10000 (bit 23 = 0) returns that index register on `rd_data_o`, with `rd_valid_o` high, in the cycle after `rd_en_i`. Otherwise `rd_valid_o` is low.
- R6: A read of an index register clears it to zero.
- R7: A read at 0x800000 + group × 0x10000 (address bits [23:20] = 4'h8) returns the group's summary. Bit k is 1 when index register k of that group is nonzero, and bits [31:8] are zero. The read changes no state.
- R8: `irq_o[g]` is high exactly while some bit in group g is pending. It follows each write or clearing read one cycle later.
- R9: When a clearing read and a valid write hit the same register in the same cycle, the read returns the earlier contents and the newly written bit stays set afterwards.
- R10: A read at any other address (bit 23 = 1 and bits [22:20] nonzero) returns zero and changes no state.
- R11: Successive writes to one register accumulate: each one sets its bit and keeps the bits already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Message write strobe |
| wr_addr_i | input | 24 | Message write address, relative to the bank base |
| wr_data_i | input | 32 | Message write data (vector bit number) |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 24 | Read address |
| rd_valid_o | output | 1 | Read data valid, one cycle after `rd_en_i` |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 16 | Level interrupt line for each group |

## Verification
The bench builds the block with its default parameters: 16 groups, 8 registers per group and 32-bit registers. With these values the full 24-bit address map and all 4096 vectors can be reached. Random traffic therefore covers every group line and every summary bit. It also reaches the out-of-range data values 32 to 39, the hole above the summary window, and collisions between clearing reads and writes.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  typedef enum logic [1:0] {
    RD_NONE    = 2'd0,
    RD_INDEX   = 2'd1,
    RD_SUMMARY = 2'd2,
    RD_HOLE    = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/msi_wr_decode.sv
module msi_wr_decode #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int FIELD_LSB = 16,
  parameter int SEL_W     = 7,
  parameter int BIT_W     = 5
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ok_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic [BIT_W-1:0]  wr_bit_o
);
  localparam int REGION_BIT = FIELD_LSB + SEL_W;

  logic addr_in_range;
  logic data_in_range;

  assign addr_in_range = (wr_addr_i >> REGION_BIT) == '0;
  assign data_in_range = (wr_data_i >> BIT_W) == '0;
  assign wr_ok_o  = wr_en_i && addr_in_range && data_in_range;
  assign wr_sel_o = wr_addr_i[FIELD_LSB +: SEL_W];
  assign wr_bit_o = wr_data_i[BIT_W-1:0];
endmodule

// File: rtl/msi_rd_decode.sv
module msi_rd_decode
  import msi_term_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int FIELD_LSB = 16,
  parameter int GRP_W     = 4,
  parameter int IDX_W     = 3
) (
  input  logic                   rd_en_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output rd_kind_e               rd_kind_o,
  output logic [GRP_W+IDX_W-1:0] rd_sel_o,
  output logic [GRP_W-1:0]       rd_grp_o
);
  localparam int SEL_W      = GRP_W + IDX_W;
  localparam int REGION_BIT = FIELD_LSB + SEL_W;
  localparam int SUM_LSB    = FIELD_LSB + GRP_W;

  logic in_index;
  logic in_summary;

  assign in_index   = (rd_addr_i >> REGION_BIT) == '0;
  // summary window: region bit set, all bits between group field and region bit clear
  assign in_summary = (rd_addr_i >> SUM_LSB) == ADDR_W'(1 << IDX_W);

  always_comb begin
    if (!rd_en_i)        rd_kind_o = RD_NONE;
    else if (in_index)   rd_kind_o = RD_INDEX;
    else if (in_summary) rd_kind_o = RD_SUMMARY;
    else                 rd_kind_o = RD_HOLE;
  end

  assign rd_sel_o = rd_addr_i[FIELD_LSB +: SEL_W];
  assign rd_grp_o = rd_addr_i[FIELD_LSB +: GRP_W];
endmodule

// File: rtl/msi_index_bank.sv
module msi_index_bank #(
  parameter int NUM_REGS = 128,
  parameter int REG_W    = 32,
  parameter int SEL_W    = 7,
  parameter int BIT_W    = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_ok_i,
  input  logic [SEL_W-1:0]                 wr_sel_i,
  input  logic [BIT_W-1:0]                 wr_bit_i,
  input  logic                             clr_i,
  input  logic [SEL_W-1:0]                 clr_sel_i,
  output logic [NUM_REGS-1:0][REG_W-1:0]   regs_o
);
  logic [REG_W-1:0] bit_mask;

  assign bit_mask = REG_W'(1) << wr_bit_i;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic             hit_set;
    logic             hit_clr;
    logic [REG_W-1:0] q;

    assign hit_set = wr_ok_i && (wr_sel_i == SEL_W'(r));
    assign hit_clr = clr_i && (clr_sel_i == SEL_W'(r));

    // clear before set so a colliding write survives the read
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (hit_set || hit_clr) begin
        q <= (hit_clr ? '0 : q) | (hit_set ? bit_mask : '0);
      end
    end

    assign regs_o[r] = q;
  end
endmodule

// File: rtl/msi_summary.sv
module msi_summary #(
  parameter int NUM_GROUPS     = 16,
  parameter int REGS_PER_GROUP = 8,
  parameter int REG_W          = 32,
  localparam int NUM_REGS      = NUM_GROUPS * REGS_PER_GROUP
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0]               regs_i,
  output logic [NUM_GROUPS-1:0][REGS_PER_GROUP-1:0]    summary_o,
  output logic [NUM_GROUPS-1:0]                        irq_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < REGS_PER_GROUP; k++) begin : g_idx
      assign summary_o[g][k] = |regs_i[g*REGS_PER_GROUP + k];
    end
    assign irq_o[g] = |summary_o[g];
  end
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_term_pkg::*;
#(
  parameter int NUM_GROUPS     = 16,
  parameter int REGS_PER_GROUP = 8,
  parameter int REG_W          = 32,
  parameter int FIELD_LSB      = 16,
  parameter int ADDR_W         = 24,
  parameter int DATA_W         = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic                  rd_valid_o,
  output logic [REG_W-1:0]      rd_data_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  localparam int GRP_W    = $clog2(NUM_GROUPS);
  localparam int IDX_W    = $clog2(REGS_PER_GROUP);
  localparam int SEL_W    = GRP_W + IDX_W;
  localparam int BIT_W    = $clog2(REG_W);
  localparam int NUM_REGS = NUM_GROUPS * REGS_PER_GROUP;

  logic                                      wr_ok;
  logic [SEL_W-1:0]                          wr_sel;
  logic [BIT_W-1:0]                          wr_bit;
  rd_kind_e                                  rd_kind;
  logic [SEL_W-1:0]                          rd_sel;
  logic [GRP_W-1:0]                          rd_grp;
  logic [NUM_REGS-1:0][REG_W-1:0]            regs;
  logic [NUM_GROUPS-1:0][REGS_PER_GROUP-1:0] summary;
  logic [REG_W-1:0]                          rd_word;
  logic                                      rd_clr;

  msi_wr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_LSB(FIELD_LSB),
    .SEL_W(SEL_W), .BIT_W(BIT_W)
  ) u_wr_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .wr_ok_o  (wr_ok),
    .wr_sel_o (wr_sel),
    .wr_bit_o (wr_bit)
  );

  msi_rd_decode #(
    .ADDR_W(ADDR_W), .FIELD_LSB(FIELD_LSB), .GRP_W(GRP_W), .IDX_W(IDX_W)
  ) u_rd_dec (
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .rd_kind_o(rd_kind),
    .rd_sel_o (rd_sel),
    .rd_grp_o (rd_grp)
  );

  assign rd_clr = (rd_kind == RD_INDEX);

  msi_index_bank #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .SEL_W(SEL_W), .BIT_W(BIT_W)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ok_i  (wr_ok),
    .wr_sel_i (wr_sel),
    .wr_bit_i (wr_bit),
    .clr_i    (rd_clr),
    .clr_sel_i(rd_sel),
    .regs_o   (regs)
  );

  msi_summary #(
    .NUM_GROUPS(NUM_GROUPS), .REGS_PER_GROUP(REGS_PER_GROUP), .REG_W(REG_W)
  ) u_sum (
    .regs_i   (regs),
    .summary_o(summary),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (rd_kind)
      RD_INDEX:   rd_word = regs[rd_sel];
      RD_SUMMARY: rd_word = REG_W'(summary[rd_grp]);
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      rd_data_o  <= rd_en_i ? rd_word : '0;
    end
  end

  AST_WR_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> regs[$past(wr_sel)][$past(wr_bit)]); // R2

  AST_BAD_DATA_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i >= DATA_W'(REG_W)) && !rd_en_i) |=> $stable(regs)); // R3

  AST_BAD_ADDR_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i[FIELD_LSB+SEL_W] && !rd_en_i) |=> $stable(regs)); // R4

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o); // R5

  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o); // R5

  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && !(wr_ok && wr_sel == rd_sel)) |=> regs[$past(rd_sel)] == '0); // R6

  AST_SUMMARY_NO_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i[FIELD_LSB+SEL_W] && !wr_en_i) |=> $stable(regs)); // R7

  AST_IRQ_RISE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~$past(irq_o)) != '0) |-> $past(wr_ok)); // R8

  AST_IRQ_FALL_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~irq_o & $past(irq_o)) != '0) |-> $past(rd_clr)); // R8

  AST_COLLIDE_KEEPS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && wr_ok && wr_sel == rd_sel) |=> $countones(regs[$past(rd_sel)]) == 1); // R9
endmodule

// File: tb/sim_msi_term_bank.sv
`timescale 1ns/1ps
module sim_msi_term_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [23:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [23:0] rd_addr_i = '0;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;
  logic [15:0] irq_o;

  int n_checks = 0, n_errors = 0;
  int c_checks = 0, c_errors = 0;
  logic [31:0] model [128];
  logic        exp_valid = 1'b0;
  logic [31:0] exp_data = '0;
  logic [31:0] rv;
  bit          done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  msi_term_bank u0 (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_en_i, .rd_addr_i, .rd_valid_o, .rd_data_o, .irq_o
  );

  // behavioural reference: read sees old contents, then clear, then set
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 128; i++) model[i] = '0;
      exp_valid = 1'b0;
      exp_data  = '0;
    end else begin
      exp_valid = rd_en_i;
      exp_data  = '0;
      if (rd_en_i) begin
        if (rd_addr_i[23] == 1'b0) begin
          exp_data = model[rd_addr_i[22:16]];
          model[rd_addr_i[22:16]] = '0;
        end else if (rd_addr_i[22:20] == 3'd0) begin
          for (int k = 0; k < 8; k++)
            exp_data[k] = (model[rd_addr_i[19:16]*8 + k] != 0);
        end
      end
      if (wr_en_i && wr_addr_i[23] == 1'b0 && wr_data_i < 32)
        model[wr_addr_i[22:16]][wr_data_i[4:0]] = 1'b1;
    end
  end

  function automatic logic [15:0] model_irq();
    logic [15:0] m = '0;
    for (int g = 0; g < 16; g++)
      for (int k = 0; k < 8; k++)
        if (model[g*8+k] != 0) m[g] = 1'b1;
    return m;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      c_checks++;
      if (irq_o !== model_irq()) begin
        c_errors++;
        $display("FAIL R8 irq_o actual %h expected %h", irq_o, model_irq());
      end
      c_checks++;
      if (rd_valid_o !== exp_valid) begin
        c_errors++;
        $display("FAIL R5 rd_valid_o actual %b expected %b", rd_valid_o, exp_valid);
      end
      if (exp_valid) begin
        c_checks++;
        if (rd_data_o !== exp_data) begin
          c_errors++;
          $display("FAIL R5/R7 rd_data_o actual %h expected %h", rd_data_o, exp_data);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [23:0] wa, input logic [31:0] wd,
                    input logic re, input logic [23:0] ra);
    @(negedge clk_i);
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    rd_en_i = re; rd_addr_i = ra;
  endtask

  task automatic idle();
    op(1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic wr(input logic [23:0] wa, input logic [31:0] wd);
    op(1'b1, wa, wd, 1'b0, '0);
    idle();
  endtask

  task automatic rd(input logic [23:0] ra, output logic [31:0] d);
    op(1'b0, '0, '0, 1'b1, ra);
    idle();
    d = rd_data_o;
  endtask

  function automatic logic [23:0] ia(input int g, input int k);
    return 24'(g * 24'h80000 + k * 24'h10000);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 irq in reset", 32'(irq_o), 32'h0);
    check("R1 rd_valid in reset", 32'(rd_valid_o), 32'h0);
    rst_ni = 1'b1;
    idle();
    rd(ia(0, 0), rv); check("R1 reg0 after reset", rv, 32'h0);
    check("R1 irq after reset", 32'(irq_o), 32'h0);

    wr(ia(3, 5) | 24'h1234, 32'd7);
    check("R8 irq after write", 32'(irq_o), 32'h0008);
    rd(24'h830000, rv); check("R7 summary g3", rv, 32'h20);
    rd(24'h830000, rv); check("R7 summary repeat", rv, 32'h20);
    rd(ia(3, 5), rv);   check("R5 index read", rv, 32'h80);
    check("R8 irq after clear", 32'(irq_o), 32'h0);
    rd(ia(3, 5), rv);   check("R6 cleared on read", rv, 32'h0);

    wr(ia(15, 7), 32'd0);
    wr(ia(15, 7), 32'd31);
    check("R2 irq g15", 32'(irq_o), 32'h8000);
    rd(ia(15, 7), rv); check("R11 accumulate", rv, 32'h8000_0001);

    wr(ia(0, 1), 32'd32);
    check("R3 irq unchanged", 32'(irq_o), 32'h0);
    rd(ia(0, 1), rv); check("R3 data>=32 ignored", rv, 32'h0);

    wr(24'h810000, 32'd3);
    check("R4 irq unchanged", 32'(irq_o), 32'h0);
    rd(24'h810000, rv); check("R4 summary g1 empty", rv, 32'h0);

    wr(ia(2, 0), 32'd1);
    rd(24'h900000, rv); check("R10 hole read", rv, 32'h0);
    rd(24'h9F0000, rv); check("R10 hole read top", rv, 32'h0);
    check("R10 no side effect irq", 32'(irq_o), 32'h0004);
    rd(24'h820000, rv); check("R7 summary g2", rv, 32'h1);
    rd(ia(2, 0), rv);   check("R10 reg kept", rv, 32'h2);

    wr(ia(1, 2), 32'd4);
    op(1'b1, ia(1, 2), 32'd9, 1'b1, ia(1, 2));
    idle();
    check("R9 read returns old", rd_data_o, 32'h10);
    check("R9 irq stays", 32'(irq_o), 32'h0002);
    rd(ia(1, 2), rv); check("R9 new bit kept", rv, 32'h200);

    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [23:0] wa, ra;
      wa = {1'($urandom % 6 == 0), 7'($urandom), 16'($urandom)};
      r = $urandom % 8;
      if (r < 5)      ra = {1'b0, 7'($urandom), 16'($urandom)};
      else if (r < 7) ra = {4'h8, 4'($urandom), 16'($urandom)};
      else            ra = {1'b1, 3'($urandom % 7 + 1), 20'($urandom)};
      op(1'($urandom % 2), wa, 32'($urandom % 40), 1'($urandom % 3 == 0), ra);
    end
    for (int i = 0; i < 128; i++) op(1'b0, '0, '0, 1'b1, 24'(i) << 16);
    idle();
    check("R6 all drained irq", 32'(irq_o), 32'h0);
    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors",
             n_checks + c_checks, n_errors + c_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors",
               n_checks + c_checks + 1, n_errors + c_errors + 1);
      $finish;
    end
  end
endmodule